// File: doc/BRIEF.md
# Multicore Hardware Barrier Unit

This block lets a group of cores meet at a global synchronization point. A core that reaches the point sends a one-cycle request on its own request line and then waits. The unit notes each arrival and holds back every waiting core. Once the last participating core has arrived, it sends a one-cycle done pulse to all participants together, and they all continue.

Which cores take part is fixed when the block is built, by a mask parameter. The two lowest-numbered cores are always excluded. Each barrier instance is tracked by sense reversal. One global phase bit flips each time a barrier completes. Each core has its own phase bit, which flips when that core's arrival is accepted. So a fast core can leave barrier j and enter barrier j+1 straight away. Its new arrival counts toward j+1 and can never be mistaken for a core that is still leaving j.

Top module: `barrier_sync`

## Requirements
- R1: Requests on core lines 0 and 1, and on any line whose bit in the participation mask is 0, are never counted. Done is never driven on those lines. With the default mask 16'hFFFC, the participants are cores 2 to 15 (bit i of each vector is core i).
- R2: Done is not asserted until every participating core has made an accepted arrival in the current barrier instance.
- R3: The last arrival's request is sampled at some clock edge k. Done is then high during the cycle that follows edge k+1, and at no other time.
- R4: Whenever done is asserted, it is asserted on all participating lines in the same cycle.
- R5: A second request from a core that has already arrived and is still waiting is ignored. It does not count twice and does not hurry completion.
- R6: A request sampled on the edge that sets done is ignored. A request sampled while done is high counts as that core's arrival at the next barrier. Cores still finishing the previous barrier are never counted as arrivals at the next one.
- R7: If every participant requests in the same cycle, done follows with the same latency as in R3, and the unit does not stall.
- R8: Synchronous active-high reset clears all phase bits and drives done low. The first barrier after reset needs a fresh arrival from every participant.
- R9: Done lasts exactly one cycle per completed barrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | One-cycle arrival request, one bit per core |
| done_o | output | 16 | One-cycle release pulse, one bit per core |

## Verification
A request that completes a barrier is sampled at one edge. Done then becomes visible one full cycle after the following edge. The driver therefore files each expected release vector under the cycle count at which the drive happened, plus two. The monitor samples done on the falling clock edge and compares it with the front of the queue when that cycle is due. In every other cycle it requires done to be all zeros. The bench model also ignores requests driven during the single cycle between the completing arrival and the visible done, so the R6 window is checked to the exact cycle.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    localparam int unsigned CORES = 16;

    typedef logic [CORES-1:0] core_vec_t;

    typedef struct packed {
        core_vec_t phase;
    } arrive_state_t;

    typedef struct packed {
        logic      gphase;
        core_vec_t done;
    } release_state_t;

    // Participation mask with every core below `first` forced out.
    function automatic core_vec_t eligible(core_vec_t mask, int unsigned first);
        core_vec_t m;
        m = mask;
        for (int unsigned i = 0; i < CORES; i++) begin
            if (i < first) m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/barrier_arrival.sv
module barrier_arrival
    import barrier_pkg::*;
#(
    parameter core_vec_t ENABLE = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  core_vec_t req_i,
    input  logic      gphase_i,
    output core_vec_t arrived_o
);

    arrive_state_t st_q, st_d;
    core_vec_t     phase_nxt;

    // One phase bit per core; a request is accepted only while the core's
    // phase still matches the global phase, i.e. it has not yet arrived.
    for (genvar i = 0; i < CORES; i++) begin : g_core
        if (ENABLE[i]) begin : g_on
            assign phase_nxt[i] = (req_i[i] && (st_q.phase[i] == gphase_i))
                                  ? ~st_q.phase[i] : st_q.phase[i];
            assign arrived_o[i] = st_q.phase[i] ^ gphase_i;
        end else begin : g_off
            assign phase_nxt[i] = 1'b0;
            assign arrived_o[i] = 1'b0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.phase = phase_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/barrier_release.sv
module barrier_release
    import barrier_pkg::*;
#(
    parameter core_vec_t ENABLE = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  core_vec_t arrived_i,
    output logic      gphase_o,
    output core_vec_t done_o
);

    release_state_t st_q, st_d;
    logic           all_in;

    always_comb begin
        all_in      = ((arrived_i & ENABLE) == ENABLE);
        st_d        = st_q;
        st_d.done   = all_in ? ENABLE : '0;
        st_d.gphase = all_in ? ~st_q.gphase : st_q.gphase;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gphase_o = st_q.gphase;
    assign done_o   = st_q.done;

endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
    import barrier_pkg::*;
#(
    parameter core_vec_t   PART_MASK  = 16'hFFFC,
    parameter int unsigned FIRST_CORE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CORES-1:0] req_i,
    output logic [CORES-1:0] done_o
);

    localparam core_vec_t ENABLE = eligible(PART_MASK, FIRST_CORE);

    core_vec_t arrived;
    logic      gphase;

    barrier_arrival #(.ENABLE(ENABLE)) u_arrival (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .gphase_i (gphase),
        .arrived_o(arrived)
    );

    barrier_release #(.ENABLE(ENABLE)) u_release (
        .clk      (clk),
        .rst      (rst),
        .arrived_i(arrived),
        .gphase_o (gphase),
        .done_o   (done_o)
    );

endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk
    import barrier_pkg::*;
#(
    parameter core_vec_t   PART_MASK  = 16'hFFFC,
    parameter int unsigned FIRST_CORE = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [CORES-1:0] req_i,
    input logic [CORES-1:0] done_o
);

    localparam core_vec_t ENABLE = eligible(PART_MASK, FIRST_CORE);

    // Port-level record of who has arrived since the last release.
    core_vec_t seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= (done_o != '0) ? (req_i & ENABLE)
                                          : (seen_q | (req_i & ENABLE));
    end

    // R1
    excluded_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o & ~ENABLE) == '0);

    // R2
    arrived_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o != '0) |-> ($past(seen_q) == ENABLE));

    // R3
    release_due_chk: assert property (@(posedge clk) disable iff (rst)
        ((seen_q == ENABLE) && (done_o == '0)) |=> (done_o != '0));

    // R4
    all_together_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o != '0) |-> (done_o == ENABLE));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o != '0) |=> (done_o == '0));

endmodule

bind barrier_sync barrier_sync_chk #(
    .PART_MASK (PART_MASK),
    .FIRST_CORE(FIRST_CORE)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .done_o(done_o)
);

// File: tb/tb_barrier_sync.sv
module tb_barrier_sync;

    localparam int   CLK_PERIOD = 10;
    localparam logic [15:0] PART = 16'hFFFC;

    typedef struct {
        int          at;
        logic [15:0] vec;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req = '0;
    logic [15:0] done;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   reported = 1'b0;
    exp_t q[$];

    logic [15:0] arrived_m = '0;
    int          block_until = 0;

    barrier_sync dut (.clk(clk), .rst(rst), .req_i(req), .done_o(done));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: cycle %0d done=%h expected %h", tag, cyc, act, expv);
        end
    endtask

    // Driver: drives one cycle of requests and predicts releases.
    task automatic drive(input logic [15:0] m, input string tag);
        logic [15:0] eff;
        exp_t        e;
        @(negedge clk);
        req = m;
        eff = (cyc < block_until) ? 16'h0 : (m & PART);
        arrived_m |= eff;
        if (arrived_m == PART) begin
            e.at = cyc + 2; e.vec = PART; e.tag = tag;
            q.push_back(e);
            arrived_m   = '0;
            block_until = cyc + 2;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(16'h0, "R2");
    endtask

    // Monitor: compares done against the scoreboard every cycle.
    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] expv;
            string       tag;
            expv = '0;
            tag  = "R2";
            if (q.size() > 0 && q[0].at == cyc) begin
                expv = q[0].vec;
                tag  = q[0].tag;
                void'(q.pop_front());
            end
            check(done === expv, tag, done, expv);
        end
    end

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: done low while in reset
        check(done === 16'h0, "R8", done, 16'h0);
        rst = 1'b0;

        // R1: excluded cores alone never release anything
        for (int i = 0; i < 6; i++) drive(16'h0003, "R1");
        idle(3);

        // R8/R3: first barrier after reset, cores arrive one by one
        for (int c = 2; c < 16; c++) begin
            drive(16'h0001 << c, "R3");
            drive(16'h0002, "R1");
        end
        idle(4);

        // R5: repeated requests from a waiting core do not count twice
        drive(16'h0020, "R5");
        drive(16'h0020, "R5");
        drive(16'h0020, "R5");
        drive(PART & ~16'h0200, "R5");
        drive(16'h0020, "R5");
        idle(3);
        drive(16'h0200, "R5");
        idle(4);

        // R7: everyone at once, including excluded lines
        drive(16'hFFFF, "R7");
        idle(4);

        // R6: request on the edge that sets done is ignored
        drive(PART, "R9");
        drive(PART, "R6");
        idle(1);
        drive(16'h0004, "R6");
        idle(5);
        drive(PART & ~16'h0004, "R6");
        idle(4);

        // R6: fast core re-enters while done is visible, several rounds
        for (int g = 0; g < 3; g++) begin
            drive(PART, "R4");
            idle(1);
            drive(16'h0008, "R6");
            idle(3);
            drive(PART & ~16'h0008, "R6");
            idle(4);
        end

        idle(4);
        check(q.size() == 0, "R3", 16'(q.size()), 16'h0);
        finish_run();
    end

endmodule